// File: doc/BRIEF.md
# Two-Wire Open-Drain Link Port

This block is an 8-bit I/O port that a processor uses to drive and sense two bidirectional link wires. The wires are pulled up and shared with a remote peer. A write loads a small drive register. Each set bit in that register pulls its wire low. Any wire that neither end pulls down floats high. The block models the wired-AND resolution inside itself: a separate input per wire carries the peer's pull-down, and the resolved levels come out on their own pins.

A read returns several fields at once: the drive register, the synchronised wire levels, and one sticky change flag per wire. The wire levels pass through a flop synchroniser before the port uses them. Every synchronised level change, rising or falling, sets that wire's flag. The flag stays set until software clears it by writing with the top bit set. This lets software that polls slowly still see a handshake state that the peer entered and left between two reads.

Top module: `link_port`

## Requirements
- R1: A write loads written bits 1:0 into the drive register (bit 0 for wire 0, bit 1 for wire 1), shown on `line_drive` one clock later. Written bits 6:2 have no effect, and read bits 1:0 return the drive register.
- R2: A wire is low when the local drive bit or the peer pull bit for it is 1, and high when both are 0 (`wire_level`, combinational).
- R3: Read bits 5:4 return the wire levels (bit 4 for wire 0, bit 5 for wire 1) after a two-flop synchroniser. A wire change caused by a write at clock edge E shows in the read data after edge E+2 and not after edge E+1.
- R4: With the peer idle, the level field (read data masked with 0x30) is 0x20 after writing 0x01, 0x00 after 0x03, 0x30 after 0x00 and 0x10 after 0x02.
- R5: Read bit 2 (wire 0) and read bit 3 (wire 1) are sticky flags. A flag sets one clock after a rising or falling change appears in its level bit, and it stays set until it is cleared.
- R6: A peer pull-down that lasts only a few clocks sets the wire's flag, and the flag is still set long after the wire has returned high.
- R7: A write with bit 7 = 1 clears both flags. A write with bit 7 = 0 leaves them as they are.
- R8: When a clearing write and a flag-setting level change meet at the same clock edge, the flag ends up set.
- R9: Read bits 7:6 are always 0.
- R10: After reset both drive bits are 0, both flags are 0, both wires are released, and the read data is 0x30 while the peer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Write strobe, one clock wide |
| wr_data | input | 8 | Write byte: bits 1:0 drive, bit 7 clears the flags |
| rd_data | output | 8 | Read byte: drive, flags, synchronised levels |
| peer_pull | input | 2 | Peer pull-down per wire, 1 = pulling low |
| line_drive | output | 2 | Local pull-down per wire, 1 = pulling low |
| wire_level | output | 2 | Resolved wire levels |

## Verification
The bench builds the block with its default parameters: an 8-bit port, two wires and a two-stage synchroniser. At these values the exact read-back codes and the two-clock and three-clock latencies from a write to the level bits and to the flags become literal numbers that the bench can check. Short peer pulses and a clearing write timed onto the same edge as a flag set reach the sticky-flag corner cases. Each check counts clocks from the write or from the peer change.

// File: rtl/link_port_pkg.sv
package link_port_pkg;
  localparam int unsigned PORT_W_DEF = 8;
  localparam int unsigned LINES_DEF  = 2;
  localparam int unsigned SYNC_DEF   = 2;

  // Field layout derived from the line count
  function automatic int unsigned flag_lsb(input int unsigned lines);
    return lines;
  endfunction

  function automatic int unsigned level_lsb(input int unsigned lines);
    return 2 * lines;
  endfunction
endpackage

// File: rtl/link_rst_sync.sv
module link_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_core_n = stage_q[1];
endmodule

// File: rtl/link_drive_reg.sv
module link_drive_reg #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] drive_q
);
  logic [W-1:0] drive_d;

  always_comb begin
    drive_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    drive_q <= '0;
    else if (load) drive_q <= drive_d;
  end
endmodule

// File: rtl/link_sync.sv
module link_sync #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic [W-1:0] stage_d;
    if (s == 0) begin : g_first
      always_comb stage_d = async_in;
    end else begin : g_next
      always_comb stage_d = chain_q[s-1];
    end
    // Released wires read high, so reset to all ones
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '1;
      else        chain_q[s] <= stage_d;
    end
  end

  assign sync_out = chain_q[DEPTH-1];
endmodule

// File: rtl/link_edge_flags.sv
module link_edge_flags #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic         clr,
  output logic [W-1:0] flag_q
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic [W-1:0] flag_d;

  for (genvar i = 0; i < W; i++) begin : g_line
    always_comb begin
      prev_d[i] = level[i];
      // A detected change wins over a clear on the same edge
      flag_d[i] = (flag_q[i] & ~clr) | (level[i] ^ prev_q[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '1;
      flag_q <= '0;
    end else begin
      prev_q <= prev_d;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/link_port.sv
module link_port
  import link_port_pkg::*;
#(
  parameter int unsigned PORT_W     = PORT_W_DEF,
  parameter int unsigned LINES      = LINES_DEF,
  parameter int unsigned SYNC_DEPTH = SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PORT_W-1:0] wr_data,
  output logic [PORT_W-1:0] rd_data,
  input  logic [LINES-1:0]  peer_pull,
  output logic [LINES-1:0]  line_drive,
  output logic [LINES-1:0]  wire_level
);
  localparam int unsigned FLAG_LSB  = flag_lsb(LINES);
  localparam int unsigned LEVEL_LSB = level_lsb(LINES);
  localparam int unsigned CLR_BIT   = PORT_W - 1;

  logic             rst_core_n;
  logic [LINES-1:0] level_s;
  logic [LINES-1:0] flags;
  logic             flag_clr;
  logic             wr_unused;

  link_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  link_drive_reg #(.W(LINES)) u_drive (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .load     (wr_en),
    .load_val (wr_data[LINES-1:0]),
    .drive_q  (line_drive)
  );

  // Wired-AND: low when either end pulls down
  always_comb begin
    wire_level = ~(line_drive | peer_pull);
  end

  link_sync #(.W(LINES), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .async_in (wire_level),
    .sync_out (level_s)
  );

  always_comb begin
    flag_clr = wr_en & wr_data[CLR_BIT];
  end

  link_edge_flags #(.W(LINES)) u_flags (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .level  (level_s),
    .clr    (flag_clr),
    .flag_q (flags)
  );

  always_comb begin
    rd_data                      = '0;
    rd_data[LINES-1:0]           = line_drive;
    rd_data[FLAG_LSB +: LINES]   = flags;
    rd_data[LEVEL_LSB +: LINES]  = level_s;
  end

  assign wr_unused = ^wr_data[CLR_BIT-1:LINES];
endmodule

// File: rtl/link_port_chk.sv
module link_port_chk #(
  parameter int unsigned PORT_W     = 8,
  parameter int unsigned LINES      = 2,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic              wr_en,
  input logic [PORT_W-1:0] wr_data,
  input logic [PORT_W-1:0] rd_data,
  input logic [LINES-1:0]  line_drive,
  input logic [LINES-1:0]  wire_level
);
  localparam int unsigned FLAG_LSB  = LINES;
  localparam int unsigned LEVEL_LSB = 2 * LINES;
  localparam int unsigned CLR_BIT   = PORT_W - 1;

  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)      age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_drive_load_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    wr_en |=> line_drive == $past(wr_data[LINES-1:0]));

  assert_flags_sticky_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(wr_en && wr_data[CLR_BIT]) |=>
      ((rd_data[FLAG_LSB +: LINES] & $past(rd_data[FLAG_LSB +: LINES]))
        == $past(rd_data[FLAG_LSB +: LINES])));

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assert_pull_low_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
      line_drive[i] |-> !wire_level[i]);

    // R6: any level change leaves a flag behind
    assert_change_flags_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
      (age_q == 2'd3 && rd_data[LEVEL_LSB+i] != $past(rd_data[LEVEL_LSB+i]))
        |=> rd_data[FLAG_LSB+i]);
  end

  if (SYNC_DEPTH == 2) begin : g_lat
    assert_sense_delay_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
      (age_q == 2'd3) |-> rd_data[LEVEL_LSB +: LINES] == $past(wire_level, 2));
  end
endmodule

bind link_port link_port_chk #(
  .PORT_W(PORT_W), .LINES(LINES), .SYNC_DEPTH(SYNC_DEPTH)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .line_drive (line_drive),
  .wire_level (wire_level)
);

// File: tb/link_port_bench.sv
`timescale 1ns/1ps
module link_port_bench;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [1:0] peer_pull;
  logic [1:0] line_drive;
  logic [1:0] wire_level;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    int        sel;   // 0 read data, 1 drive, 2 wire levels
    logic [7:0] mask;
    logic [7:0] val;
    string     tag;
  } exp_t;
  exp_t sb_q[$];

  link_port u_link_port (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .peer_pull(peer_pull),
    .line_drive(line_drive), .wire_level(wire_level)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  // Monitor: items pushed at a falling edge are compared after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = sb_q.pop_front();
        act = (e.sel == 0) ? rd_data :
              (e.sel == 1) ? {6'b0, line_drive} : {6'b0, wire_level};
        checks++;
        if ((act & e.mask) !== (e.val & e.mask)) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h mask=%02h",
                   e.tag, act & e.mask, e.val & e.mask, e.mask);
        end
      end
    end
  end

  task automatic expect_v(input int sel, input logic [7:0] mask,
                          input logic [7:0] val, input string tag);
    exp_t e;
    e.sel = sel; e.mask = mask; e.val = val; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; peer_pull = 0;
    idle(4);
    rst_n = 1;
    idle(4);
    expect_v(0, 8'hFF, 8'h30, "R10 reset read");
    expect_v(1, 8'hFF, 8'h00, "R10 reset drive");
    expect_v(2, 8'hFF, 8'h03, "R10 reset wires");
    idle(1);

    // Exact latency after a write at edge E
    wr(8'h01);
    expect_v(0, 8'h30, 8'h30, "R3 level not yet after E+1");
    expect_v(1, 8'hFF, 8'h01, "R1 drive loaded");
    expect_v(2, 8'hFF, 8'h02, "R2 local pull low");
    idle(1);
    expect_v(0, 8'h3C, 8'h20, "R3 level after E+2, R4 0x01");
    idle(1);
    expect_v(0, 8'hFF, 8'h25, "R5 flag set after E+3, R1 mirror");
    idle(1);

    wr(8'h83);
    idle(4);
    expect_v(0, 8'hFF, 8'h0B, "R4 0x03 reads 0x00, R5 falling edge flag");
    idle(1);

    wr(8'h80);
    idle(4);
    expect_v(0, 8'hFF, 8'h3C, "R4 0x00 reads 0x30, R5 rising flags");
    idle(1);

    wr(8'h82);
    idle(4);
    expect_v(0, 8'hFF, 8'h1A, "R4 0x02 reads 0x10");
    idle(1);

    wr(8'h7C);
    idle(4);
    expect_v(1, 8'hFF, 8'h00, "R1 bits 6:2 ignored");
    expect_v(0, 8'hFF, 8'h38, "R7 no clear without bit7, R9 spare zero");
    idle(1);

    wr(8'h80);
    idle(4);
    expect_v(0, 8'hFF, 8'h30, "R7 clear");
    idle(1);

    // Peer side of the wired-AND
    peer_pull = 2'b10;
    expect_v(2, 8'hFF, 8'h01, "R2 peer pull low");
    idle(4);
    expect_v(0, 8'hFF, 8'h18, "R2 peer level sensed");
    idle(1);
    wr(8'h81);
    expect_v(2, 8'hFF, 8'h00, "R2 both ends pulling");
    idle(1);
    peer_pull = 2'b00;
    expect_v(2, 8'hFF, 8'h02, "R2 peer released");
    idle(1);
    wr(8'h80);
    idle(4);
    wr(8'h80);
    idle(4);
    expect_v(0, 8'hFF, 8'h30, "R7 clean slate");
    idle(1);

    // Short pulse between polls
    peer_pull = 2'b01;
    idle(2);
    peer_pull = 2'b00;
    idle(6);
    expect_v(0, 8'hFF, 8'h34, "R6 short pulse captured");
    idle(1);
    wr(8'h80);
    idle(4);
    expect_v(0, 8'hFF, 8'h30, "R7 cleared after pulse");
    idle(1);

    // Clear and set on the same edge
    peer_pull = 2'b01;   // stage 1 at E0, level at E1, flag at E2
    idle(1);
    idle(1);
    wr_en = 1; wr_data = 8'h80;
    idle(1);
    wr_en = 0; wr_data = 8'h00;
    idle(2);
    expect_v(0, 8'hFF, 8'h24, "R8 set wins over clear");
    idle(1);
    peer_pull = 2'b00;
    wr(8'h80);
    idle(4);
    wr(8'h80);
    idle(4);
    expect_v(0, 8'hFF, 8'h30, "R9 R10 idle read");
    idle(3);

    done = 1;
    finish_run();
  end
endmodule